// File: doc/BRIEF.md
# Thread Request Coalescer

This block takes one group of sixteen per-thread memory requests and turns it into the shortest list of aligned memory transactions that covers every active thread. Each thread supplies an active bit and a byte address. One word-size code applies to the whole group. The block plans the transactions and issues them one after another. It never moves data. Caching and the memory access itself belong to the logic downstream.

Planning works in rounds. Each round starts with the lowest-numbered thread still waiting, which is the leader. The round collects every other waiting thread whose address lies in the same aligned segment as the leader's. The segment width grows with the word size. The transaction is then shrunk to the smallest aligned half that still holds all of the collected threads. The issued transaction carries an aligned base address, a size code and a thread mask. Those threads are retired, and the next round begins.

The group enters on a valid/ready handshake. `grp_ready` is high only while no group is in progress. Transactions leave on a second valid/ready handshake. While `txn_ready` is low, the current transaction is held unchanged. After the last transaction, `grp_done` pulses for one cycle and the block becomes ready again.

Top module: `tcoal_top`

## Requirements
- R1: `grp_ready` is high exactly when no group is in progress. A group is taken on a cycle with `grp_valid` and `grp_ready` both high. No new group is taken between acceptance and the `grp_done` pulse.
- R2: Every transaction includes the lowest-numbered thread that is still waiting when the transaction is presented.
- R3: The segment width depends on `grp_wsize`. Code 0 (1-byte words) gives 32 bytes, code 1 (2-byte words) gives 64 bytes, and code 2 (4-byte words) gives 128 bytes. Code 3 is treated as code 2.
- R4: A transaction's mask holds every waiting thread whose address shares the leader's aligned segment, and no other thread.
- R5: The size code `txn_size` means 0 = 32 bytes, 1 = 64 bytes and 2 = 128 bytes. A 128-byte segment whose threads all lie in one 64-byte half is cut to 64 bytes. A 64-byte region whose threads all lie in one 32-byte half is cut to 32 bytes. The cuts are applied in turn.
- R6: `txn_base` is the leader's address rounded down to the issued size, so it is always aligned to that size.
- R7: A thread whose active bit was low when the group was taken never appears in any mask.
- R8: Every active thread appears in exactly one mask. Rounds continue until no thread is left waiting.
- R9: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_base`, `txn_size` and `txn_mask` hold their values.
- R10: `grp_done` is a one-cycle pulse. It appears in the cycle after the last transaction handshake. For a group with no active thread, it appears in the cycle after acceptance, and no transaction is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A request group is offered |
| grp_ready | output | 1 | Block is idle and can take a group |
| grp_active | input | NT | Per-thread active bits |
| grp_addr | input | NT*AW | Per-thread byte addresses; thread i occupies bits i*AW and up |
| grp_wsize | input | 2 | Word-size code shared by the group |
| txn_valid | output | 1 | A transaction is presented |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_base | output | AW | Aligned base address |
| txn_size | output | 2 | Transaction size code |
| txn_mask | output | NT | Threads served by the transaction |
| grp_done | output | 1 | One-cycle pulse after the group is fully issued |

## Verification
The assertions assume that each thread address is aligned to the group's word size. Under that assumption, a word never straddles a 32-byte half, so checking addresses alone is enough to cut a segment correctly. They also assume that `grp_valid` is raised only with a word-size code of 0 to 2. The stimulus rounds every generated address down to the word size and uses only those three codes. It mixes sequential, strided, reversed and scattered address patterns with several active masks and with random back-pressure on `txn_ready`.

// File: rtl/tcoal_pkg.sv
package tcoal_pkg;
  // log2 of the smallest transaction, in bytes
  localparam int unsigned MIN_LG = 5;

  typedef enum logic [1:0] {
    WS_B1 = 2'd0,
    WS_B2 = 2'd1,
    WS_B4 = 2'd2
  } wsize_e;

  typedef enum logic [1:0] {
    SZ_32  = 2'd0,
    SZ_64  = 2'd1,
    SZ_128 = 2'd2
  } tsize_e;

  // code 3 is folded onto the 4-byte case
  function automatic logic [1:0] clamp_ws(input logic [1:0] ws);
    return (ws == 2'd3) ? 2'(WS_B4) : ws;
  endfunction
endpackage

// File: rtl/tcoal_leader.sv
module tcoal_leader #(
  parameter int NT = 16,
  localparam int IW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [NT-1:0] pend,
  output logic [IW-1:0] lead_idx
);
  // lowest set bit wins
  always_comb begin
    lead_idx = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (pend[i]) lead_idx = IW'(i);
    end
  end
endmodule

// File: rtl/tcoal_group.sv
module tcoal_group
  import tcoal_pkg::*;
#(
  parameter int NT = 16,
  parameter int AW = 32,
  localparam int IW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [NT*AW-1:0] addr_flat,
  input  logic [NT-1:0]    pend,
  input  logic [IW-1:0]    lead_idx,
  input  logic [1:0]       ws,
  output logic [NT-1:0]    mask,
  output logic [1:0]       size_code,
  output logic [AW-1:0]    base
);
  logic [AW-1:0] a [NT];
  logic [AW-1:0] lead_a;
  logic [2:0]    seg_lg;
  logic [AW-1:0] seg_keep;
  logic [NT-1:0] off6, off5;
  logic          any6, any5;
  logic [2:0]    lg;

  always_comb begin
    seg_lg   = 3'(MIN_LG) + {1'b0, ws};
    seg_keep = ~((AW'(1) << seg_lg) - AW'(1));
  end

  assign lead_a = a[lead_idx];

  for (genvar i = 0; i < NT; i++) begin : g_thr
    assign a[i]    = addr_flat[i*AW +: AW];
    assign mask[i] = pend[i] && (((a[i] ^ lead_a) & seg_keep) == '0);
    assign off6[i] = mask[i] && (a[i][6] != lead_a[6]);
    assign off5[i] = mask[i] && (a[i][5] != lead_a[5]);
  end

  assign any6 = |off6;
  assign any5 = |off5;

  always_comb begin
    case (ws)
      2'(WS_B4): lg = any6 ? 3'd7 : (any5 ? 3'd6 : 3'd5);
      2'(WS_B2): lg = any5 ? 3'd6 : 3'd5;
      default:   lg = 3'd5;
    endcase
    size_code = 2'(lg - 3'(MIN_LG));
    base      = lead_a & ~((AW'(1) << lg) - AW'(1));
  end
endmodule

// File: rtl/tcoal_top.sv
module tcoal_top
  import tcoal_pkg::*;
#(
  parameter int NT = 16,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grp_valid,
  output logic          grp_ready,
  input  logic [NT-1:0] grp_active,
  input  logic [NT*AW-1:0] grp_addr,
  input  logic [1:0]    grp_wsize,
  output logic          txn_valid,
  input  logic          txn_ready,
  output logic [AW-1:0] txn_base,
  output logic [1:0]    txn_size,
  output logic [NT-1:0] txn_mask,
  output logic          grp_done
);
  localparam int IW = (NT > 1) ? $clog2(NT) : 1;

  typedef enum logic {ST_IDLE, ST_BUSY} st_e;

  st_e             st;
  logic [NT-1:0]   pend;
  logic [NT*AW-1:0] addr_q;
  logic [1:0]      ws_q;
  logic [IW-1:0]   lead_idx;
  logic            accept, fire;

  assign grp_ready = (st == ST_IDLE);
  assign accept    = grp_valid && grp_ready;
  assign txn_valid = (st == ST_BUSY) && (pend != '0);
  assign grp_done  = (st == ST_BUSY) && (pend == '0);
  assign fire      = txn_valid && txn_ready;

  tcoal_leader #(.NT(NT)) u_lead (
    .pend     (pend),
    .lead_idx (lead_idx)
  );

  tcoal_group #(.NT(NT), .AW(AW)) u_grp (
    .addr_flat (addr_q),
    .pend      (pend),
    .lead_idx  (lead_idx),
    .ws        (ws_q),
    .mask      (txn_mask),
    .size_code (txn_size),
    .base      (txn_base)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pend   <= '0;
      addr_q <= '0;
      ws_q   <= '0;
    end else if (st == ST_IDLE) begin
      if (accept) begin
        st     <= ST_BUSY;
        pend   <= grp_active;
        addr_q <= grp_addr;
        ws_q   <= clamp_ws(grp_wsize);
      end
    end else begin
      if (fire) pend <= pend & ~txn_mask;
      if (grp_done) st <= ST_IDLE;
    end
  end
endmodule

// File: rtl/tcoal_checker.sv
module tcoal_checker #(
  parameter int NT = 16,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          grp_valid,
  input logic          grp_ready,
  input logic [NT-1:0] grp_active,
  input logic          txn_valid,
  input logic          txn_ready,
  input logic [AW-1:0] txn_base,
  input logic [1:0]    txn_size,
  input logic [NT-1:0] txn_mask,
  input logic          grp_done
);
  logic [NT-1:0] act_q, served;
  logic          aligned;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      served <= '0;
    end else if (grp_valid && grp_ready) begin
      act_q  <= grp_active;
      served <= '0;
    end else if (txn_valid && txn_ready) begin
      served <= served | txn_mask;
    end
  end

  always_comb begin
    case (txn_size)
      2'd0:    aligned = (txn_base[4:0] == '0);
      2'd1:    aligned = (txn_base[5:0] == '0);
      2'd2:    aligned = (txn_base[6:0] == '0);
      default: aligned = 1'b0;
    endcase
  end

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid || grp_done) |-> !grp_ready);

  assert_mask_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_mask & ~act_q) == '0));

  assert_no_reserve_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_mask & served) == '0) && (txn_mask != '0));

  assert_all_served_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |-> (served == act_q));

  assert_base_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> aligned);

  assert_size_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_size != 2'd3));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> txn_valid && $stable(txn_base)
                                  && $stable(txn_size) && $stable(txn_mask));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> !grp_done);
endmodule

bind tcoal_top tcoal_checker #(.NT(NT), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .grp_valid  (grp_valid),
  .grp_ready  (grp_ready),
  .grp_active (grp_active),
  .txn_valid  (txn_valid),
  .txn_ready  (txn_ready),
  .txn_base   (txn_base),
  .txn_size   (txn_size),
  .txn_mask   (txn_mask),
  .grp_done   (grp_done)
);

// File: tb/tcoal_top_test.sv
module tcoal_top_test;
  localparam int NT = 16;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          grp_valid = 1'b0;
  logic          grp_ready;
  logic [NT-1:0] grp_active = '0;
  logic [NT*AW-1:0] grp_addr = '0;
  logic [1:0]    grp_wsize = '0;
  logic          txn_valid;
  logic          txn_ready = 1'b0;
  logic [AW-1:0] txn_base;
  logic [1:0]    txn_size;
  logic [NT-1:0] txn_mask;
  logic          grp_done;

  int n_tests = 0;
  int n_fail = 0;

  logic [AW-1:0] ta [NT];
  logic [AW-1:0] eb [NT];
  logic [1:0]    es [NT];
  logic [NT-1:0] em [NT];
  int            en;
  logic [31:0]   seed = 32'h1234_5678;

  always #4 clk = ~clk;

  tcoal_top #(.NT(NT), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .grp_valid(grp_valid), .grp_ready(grp_ready),
    .grp_active(grp_active), .grp_addr(grp_addr), .grp_wsize(grp_wsize),
    .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_base(txn_base), .txn_size(txn_size), .txn_mask(txn_mask),
    .grp_done(grp_done)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Independent model: greedy rounds on the word size, then halving.
  task automatic build_expect(input logic [NT-1:0] act, input int ws);
    logic [NT-1:0] left;
    int lead, lg, bytes_lg;
    left = act;
    en = 0;
    bytes_lg = 5 + ws;
    while (left != '0) begin
      lead = 0;
      for (int i = NT - 1; i >= 0; i--) if (left[i]) lead = i;
      em[en] = '0;
      for (int i = 0; i < NT; i++)
        if (left[i] && (ta[i] >> bytes_lg) == (ta[lead] >> bytes_lg)) em[en][i] = 1'b1;
      lg = bytes_lg;
      while (lg > 5) begin
        bit fits;
        fits = 1'b1;
        for (int i = 0; i < NT; i++)
          if (em[en][i] && (ta[i] >> (lg - 1)) != (ta[lead] >> (lg - 1))) fits = 1'b0;
        if (!fits) break;
        lg--;
      end
      es[en] = 2'(lg - 5);
      eb[en] = (ta[lead] >> lg) << lg;
      left = left & ~em[en];
      en++;
    end
  endtask

  task automatic run_group(input logic [NT-1:0] act, input int ws, input bit stall);
    int idx, cyc, last_fire;
    bit held, ended;
    logic [AW-1:0] pb; logic [1:0] ps; logic [NT-1:0] pm;
    build_expect(act, ws);
    for (int i = 0; i < NT; i++) grp_addr[i*AW +: AW] = ta[i];
    grp_active = act;
    grp_wsize  = 2'(ws);
    grp_valid  = 1'b1;
    chk(grp_ready == 1'b1, "R1", "ready when idle", 64'(grp_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    grp_valid = 1'b0;
    grp_active = ~act;
    idx = 0; cyc = 0; last_fire = -1; held = 0; ended = 0;
    pb = '0; ps = '0; pm = '0;
    while (!ended && cyc < 300) begin
      txn_ready = stall ? ((rnd() >> 7) % 3 != 0) : 1'b1;
      #1;
      if (held)
        chk(txn_valid && txn_base == pb && txn_size == ps && txn_mask == pm,
            "R9", "held under back-pressure", 64'(txn_mask), 64'(pm));
      if (cyc == 0)
        chk(grp_ready == 1'b0, "R1", "not ready while busy", 64'(grp_ready), 64'd0);
      if (txn_valid) begin
        if (idx >= en) begin
          chk(1'b0, "R8", "extra transaction", 64'(idx), 64'(en));
        end else if (txn_ready) begin
          chk(txn_mask == em[idx], "R2,R3,R4,R7", "mask", 64'(txn_mask), 64'(em[idx]));
          chk(txn_size == es[idx], "R5", "size", 64'(txn_size), 64'(es[idx]));
          chk(txn_base == eb[idx], "R6", "base", 64'(txn_base), 64'(eb[idx]));
          idx++;
          last_fire = cyc;
        end
      end
      held = txn_valid && !txn_ready;
      pb = txn_base; ps = txn_size; pm = txn_mask;
      if (grp_done) begin
        chk(idx == en, "R8", "transaction count", 64'(idx), 64'(en));
        chk(cyc == last_fire + 1, "R10", "done timing", 64'(cyc), 64'(last_fire + 1));
        ended = 1;
      end
      @(negedge clk);
      cyc++;
    end
    if (!ended) chk(1'b0, "R10", "done never seen", 64'(cyc), 64'd0);
    #1;
    chk(grp_done == 1'b0 && grp_ready == 1'b1, "R10", "single-cycle done",
        64'(grp_done), 64'd0);
    txn_ready = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(grp_ready == 1'b1 && txn_valid == 1'b0 && grp_done == 1'b0,
        "R1", "reset state", {61'd0, grp_ready, txn_valid, grp_done}, 64'b100);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: 4-byte words in one 64-byte half collapse to a 64-byte txn.
    for (int i = 0; i < NT; i++) ta[i] = 32'h100 + 32'(4 * i);
    run_group('1, 2, 1'b0);
    chk(en == 1 && es[0] == 2'd1, "R5", "model directed", 64'(es[0]), 64'd1);

    for (int ws = 0; ws < 3; ws++) begin
      for (int mode = 0; mode < 5; mode++) begin
        for (int t = 0; t < 40; t++) begin
          logic [NT-1:0] act;
          logic [AW-1:0] wb, b0;
          wb = AW'(1) << ws;
          b0 = (rnd() & 32'h3FF) & ~(wb - 1);
          for (int i = 0; i < NT; i++) begin
            case (mode)
              0: ta[i] = b0 + wb * AW'(i);
              1: ta[i] = b0 + 2 * wb * AW'(i);
              2: ta[i] = b0 + wb * AW'(NT - 1 - i);
              3: ta[i] = (rnd() & 32'h1FF) & ~(wb - 1);
              default: ta[i] = 32'h400 + ((rnd() & 32'h7F) & ~(wb - 1));
            endcase
          end
          case (t)
            0: act = '1;
            1: act = '0;
            2: act = NT'(1) << (ws * 5 + mode);
            default: act = NT'(rnd() >> 9);
          endcase
          run_group(act, ws, t[0]);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule